// File: doc/BRIEF.md
# Interrupt Source Selection Multiplexer

This block sits between a small set of processor-side interrupt sources and a downstream interrupt controller. Eight sources come in: two trigger-interface lines, two performance-monitor lines, one cache-controller line and three external lines. Two normal-interrupt outputs and two fast-interrupt outputs go out. Each output channel carries one of the eight sources. A single packed configuration register chooses that source, and a per-source enable bit then gates it. The three external inputs can be inverted as a group so that active-low external lines can be used.

Software can rewrite the configuration register at any time, for example after a return from a low-power state. A write carries a bit mask, so only the selected configuration bits change. The outputs are registered. A configuration change reaches the outputs on the clock edge that follows the edge that stores it.

Top module: `irq_source_mux`

## Requirements
- R1: Only register bits 20:0 hold configuration. A write never stores anything above bit 20, and `cfg_rdata[31:21]` always reads zero.
- R2: When `cfg_we` is high, each configuration bit whose `cfg_wmask` bit is 1 takes the `cfg_wdata` bit, and every other bit keeps its value. When `cfg_we` is low, the register does not change, whatever `cfg_wdata` and `cfg_wmask` hold.
- R3: Bit i (i = 0..7) enables source i, and source i is `src_in[i]`. The sources in index order are: trigger-interface 0, trigger-interface 1, perf-monitor 0, perf-monitor 1, cache controller, external 0, external 1, external 2.
- R4: An output channel is 1 only when its selected source, after any inversion, is 1 and that source's enable bit is set. A channel whose selected source is disabled drives 0.
- R5: Fast channel c (c = 0, 1) reads a 3-bit select at bits 8+3c upward (10:8 and 13:11). Normal channel c reads a 3-bit select at bits 14+3c upward (16:14 and 19:17). A select value v picks source v.
- R6: When bit 20 is set, sources 5, 6 and 7 (the external lines) are inverted before gating and selection. Sources 0 to 4 are never inverted.
- R7: Outputs are registered. A write stored at clock edge k shows on the outputs after edge k+1, and a change on `src_in` shows on the outputs after the next edge.
- R8: Reset (`rst_n` low) clears the whole register and drives all four outputs to 0.
- R9: The four channels select independently. Any channels may carry the same source or different sources at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_wmask | input | 32 | Per-bit write mask (1 = update the bit) |
| cfg_rdata | output | 32 | Configuration readback, bits above 20 are zero |
| src_in | input | 8 | Interrupt sources, index order as in R3 |
| norm_irq | output | 2 | Normal-interrupt channels |
| fast_irq | output | 2 | Fast-interrupt channels |

## Verification
The bench builds the block with its default parameters: 32-bit register, eight sources, two channels of each kind, and external lines starting at source 5. These values make the field layout in R5 and the inversion group in R6 land on the exact bit positions named. The bench can therefore route each source in turn to all four channels and compare the outputs against a model derived from the field positions. It also measures the one-edge output latency after a masked write that touches a single enable bit.

// File: rtl/irq_mux_pkg.sv
package irq_mux_pkg;

   // Default geometry of the source multiplexer
   localparam int unsigned DEF_REG_W  = 32;
   localparam int unsigned DEF_SRC_N  = 8;
   localparam int unsigned DEF_CHAN_N = 2;
   localparam int unsigned DEF_EXT_LO = 5;

   // Number of bits needed to select one of src_n sources
   function automatic int unsigned sel_width(input int unsigned src_n);
      return (src_n <= 1) ? 1 : $clog2(src_n);
   endfunction

   // Low bit of the fast-channel select field for channel c
   function automatic int unsigned fast_lsb(input int unsigned src_n,
                                            input int unsigned c);
      return src_n + c * sel_width(src_n);
   endfunction

   // Low bit of the normal-channel select field for channel c
   function automatic int unsigned norm_lsb(input int unsigned src_n,
                                            input int unsigned chan_n,
                                            input int unsigned c);
      return src_n + (chan_n + c) * sel_width(src_n);
   endfunction

   // Position of the external-polarity control bit
   function automatic int unsigned inv_pos(input int unsigned src_n,
                                           input int unsigned chan_n);
      return src_n + 2 * chan_n * sel_width(src_n);
   endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned CFG_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] wmask,
   output logic [CFG_W-1:0] cfg_q
);

   logic [CFG_W-1:0] nxt;
   logic             unused_upper;

   // Bits above the configuration field are dropped here
   assign unused_upper = ^{wdata[REG_W-1:CFG_W], wmask[REG_W-1:CFG_W]};

   always_comb begin
      nxt = (cfg_q & ~wmask[CFG_W-1:0]) | (wdata[CFG_W-1:0] & wmask[CFG_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we) begin
         cfg_q <= nxt;
      end
   end

endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
   parameter int unsigned SRC_N  = 8,
   parameter int unsigned EXT_LO = 5
) (
   input  logic [SRC_N-1:0] src,
   input  logic [SRC_N-1:0] en,
   input  logic             ext_inv,
   output logic [SRC_N-1:0] cond
);

   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      if (i >= EXT_LO) begin : g_ext
         // External line: polarity chosen by the inversion control
         assign cond[i] = (src[i] ^ ext_inv) & en[i];
      end else begin : g_int
         // Internal line: always active high
         assign cond[i] = src[i] & en[i];
      end
   end

endmodule

// File: rtl/irq_chan_sel.sv
module irq_chan_sel #(
   parameter int unsigned SRC_N = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] cond,
   input  logic [SEL_W-1:0] sel,
   output logic             irq_q
);

   logic pick;

   always_comb begin
      pick = 1'b0;
      for (int s = 0; s < SRC_N; s++) begin
         if (sel == SEL_W'(s)) pick = cond[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= pick;
      end
   end

endmodule

// File: rtl/irq_source_mux.sv
module irq_source_mux #(
   parameter int unsigned REG_W  = irq_mux_pkg::DEF_REG_W,
   parameter int unsigned SRC_N  = irq_mux_pkg::DEF_SRC_N,
   parameter int unsigned CHAN_N = irq_mux_pkg::DEF_CHAN_N,
   parameter int unsigned EXT_LO = irq_mux_pkg::DEF_EXT_LO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic [REG_W-1:0]  cfg_wmask,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic [SRC_N-1:0]  src_in,
   output logic [CHAN_N-1:0] norm_irq,
   output logic [CHAN_N-1:0] fast_irq
);

   localparam int unsigned SEL_W   = irq_mux_pkg::sel_width(SRC_N);
   localparam int unsigned INV_POS = irq_mux_pkg::inv_pos(SRC_N, CHAN_N);
   localparam int unsigned CFG_W   = INV_POS + 1;

   // Elaboration-time parameter checks
   if (CFG_W > REG_W) begin : g_bad_width
      $error("configuration field does not fit the register");
   end
   if ((1 << SEL_W) != SRC_N) begin : g_bad_src
      $error("source count must be a power of two");
   end
   if (EXT_LO >= SRC_N) begin : g_bad_ext
      $error("external group must start inside the source range");
   end

   logic [CFG_W-1:0] cfg_q;
   logic [SRC_N-1:0] cond;

   irq_cfg_reg #(
      .REG_W (REG_W),
      .CFG_W (CFG_W)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .wmask (cfg_wmask),
      .cfg_q (cfg_q)
   );

   if (REG_W > CFG_W) begin : g_rd_pad
      assign cfg_rdata = {{(REG_W-CFG_W){1'b0}}, cfg_q};
   end else begin : g_rd_full
      assign cfg_rdata = cfg_q;
   end

   irq_src_cond #(
      .SRC_N  (SRC_N),
      .EXT_LO (EXT_LO)
   ) u_cond (
      .src     (src_in),
      .en      (cfg_q[SRC_N-1:0]),
      .ext_inv (cfg_q[INV_POS]),
      .cond    (cond)
   );

   for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
      localparam int unsigned F_LO = irq_mux_pkg::fast_lsb(SRC_N, c);
      localparam int unsigned N_LO = irq_mux_pkg::norm_lsb(SRC_N, CHAN_N, c);

      irq_chan_sel #(
         .SRC_N (SRC_N),
         .SEL_W (SEL_W)
      ) u_fast (
         .clk   (clk),
         .rst_n (rst_n),
         .cond  (cond),
         .sel   (cfg_q[F_LO +: SEL_W]),
         .irq_q (fast_irq[c])
      );

      irq_chan_sel #(
         .SRC_N (SRC_N),
         .SEL_W (SEL_W)
      ) u_norm (
         .clk   (clk),
         .rst_n (rst_n),
         .cond  (cond),
         .sel   (cfg_q[N_LO +: SEL_W]),
         .irq_q (norm_irq[c])
      );
   end

endmodule

// File: rtl/irq_source_mux_chk.sv
module irq_source_mux_chk #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned SRC_N  = 8,
   parameter int unsigned CHAN_N = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [REG_W-1:0]  cfg_wdata,
   input logic [REG_W-1:0]  cfg_wmask,
   input logic [REG_W-1:0]  cfg_rdata,
   input logic [SRC_N-1:0]  src_in,
   input logic [CHAN_N-1:0] norm_irq,
   input logic [CHAN_N-1:0] fast_irq
);

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (cfg_rdata == '0 && norm_irq == '0 && fast_irq == '0); // R8
      end
   end

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[REG_W-1:21] == '0); // R1

   AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_rdata[20:0] == (($past(cfg_rdata[20:0]) & ~$past(cfg_wmask[20:0]))
                                   | ($past(cfg_wdata[20:0]) & $past(cfg_wmask[20:0])))); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_rdata)); // R2

   AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[7:0] == 8'h00) |=> (norm_irq == '0 && fast_irq == '0)); // R4

   AST_FAST0_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      fast_irq[0] |-> $past(cfg_rdata[cfg_rdata[10:8]])); // R4

   AST_NORM1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      norm_irq[1] |-> $past(cfg_rdata[cfg_rdata[19:17]])); // R5

   AST_FAST0_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      fast_irq[0] |-> $past(src_in[cfg_rdata[10:8]]
                            ^ (cfg_rdata[20] && (cfg_rdata[10:8] >= 3'd5)))); // R6

   logic unused_chk;
   assign unused_chk = ^{cfg_wdata[REG_W-1:21], cfg_wmask[REG_W-1:21]};

endmodule

bind irq_source_mux irq_source_mux_chk #(
   .REG_W  (REG_W),
   .SRC_N  (SRC_N),
   .CHAN_N (CHAN_N)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_wmask (cfg_wmask),
   .cfg_rdata (cfg_rdata),
   .src_in    (src_in),
   .norm_irq  (norm_irq),
   .fast_irq  (fast_irq)
);

// File: tb/irq_source_mux_bench.sv
module irq_source_mux_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_wmask = '0;
   logic [31:0] cfg_rdata;
   logic [7:0]  src_in = '0;
   logic [1:0]  norm_irq;
   logic [1:0]  fast_irq;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] cfg_m = '0;

   always #10 clk = ~clk;

   irq_source_mux u_irq_source_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_wmask (cfg_wmask),
      .cfg_rdata (cfg_rdata),
      .src_in    (src_in),
      .norm_irq  (norm_irq),
      .fast_irq  (fast_irq)
   );

   // Compose a configuration word from R3/R5/R6 field positions
   function automatic logic [31:0] mk(input logic [7:0] en, input logic [2:0] f0,
                                      input logic [2:0] f1, input logic [2:0] n0,
                                      input logic [2:0] n1, input logic inv);
      return {11'd0, inv, n1, n0, f1, f0, en};
   endfunction

   // Expected {norm1, norm0, fast1, fast0}
   function automatic logic [3:0] model(input logic [31:0] c, input logic [7:0] s);
      logic [7:0] eff;
      logic [3:0] r;
      eff = (s ^ (c[20] ? 8'hE0 : 8'h00)) & c[7:0];
      r[0] = eff[c[10:8]];
      r[1] = eff[c[13:11]];
      r[2] = eff[c[16:14]];
      r[3] = eff[c[19:17]];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d, input logic [31:0] m);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = d; cfg_wmask = m;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = '0; cfg_wmask = '0;
      cfg_m = (cfg_m & ~(m & 32'h001F_FFFF)) | (d & m & 32'h001F_FFFF);
   endtask

   task automatic chk_outs(input string tag);
      @(negedge clk);
      @(negedge clk);
      chk(tag, {28'd0, norm_irq, fast_irq}, {28'd0, model(cfg_m, src_in)});
   endtask

   task automatic t_reset();
      src_in = 8'hFF;
      repeat (3) @(negedge clk);
      chk("R8 reset readback", cfg_rdata, 32'h0);
      chk("R8 reset outputs", {28'd0, norm_irq, fast_irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 outputs after release", {28'd0, norm_irq, fast_irq}, 32'h0);
   endtask

   task automatic t_upper();
      src_in = 8'hFF;
      wr(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      chk("R1 upper bits read zero", cfg_rdata, 32'h001F_FFFF);
      chk_outs("R1 outputs all-ones config");
   endtask

   task automatic t_mask();
      wr(32'h0, 32'hFFFF_FFFF);
      wr(32'h0015_5555, 32'h000F_0F0F);
      chk("R2 masked write", cfg_rdata, 32'h0005_0505);
      chk("R2 model agree", cfg_rdata, cfg_m);
      @(negedge clk);
      cfg_wdata = 32'hFFFF_FFFF; cfg_wmask = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      chk("R2 no write when strobe low", cfg_rdata, 32'h0005_0505);
      cfg_wdata = '0; cfg_wmask = '0;
   endtask

   task automatic t_route();
      for (int s = 0; s < 8; s++) begin
         wr(mk(8'(1 << s), 3'(s), 3'(s), 3'(s), 3'(s), 1'b0), 32'hFFFF_FFFF);
         src_in = 8'(1 << s);
         chk_outs("R3 single source to all channels");
         chk("R3 all four high", {28'd0, norm_irq, fast_irq}, 32'hF);
         src_in = ~8'(1 << s);
         chk_outs("R3 other sources unselected");
      end
   endtask

   task automatic t_disabled();
      wr(mk(8'hFB, 3'd2, 3'd2, 3'd2, 3'd2, 1'b0), 32'hFFFF_FFFF);
      src_in = 8'hFF;
      chk_outs("R4 disabled source drives zero");
      chk("R4 explicit zero", {28'd0, norm_irq, fast_irq}, 32'h0);
      wr(mk(8'h04, 3'd2, 3'd2, 3'd2, 3'd2, 1'b0), 32'hFFFF_FFFF);
      src_in = 8'hFB;
      chk_outs("R4 enabled but idle source");
   endtask

   task automatic t_fields();
      wr(mk(8'hFF, 3'd1, 3'd3, 3'd4, 3'd6, 1'b0), 32'hFFFF_FFFF);
      src_in = 8'h02;
      chk_outs("R5 fast0 field");
      chk("R5 only fast0", {28'd0, norm_irq, fast_irq}, 32'h1);
      src_in = 8'h40;
      chk_outs("R5 norm1 field");
      chk("R5 only norm1", {28'd0, norm_irq, fast_irq}, 32'h8);
      src_in = 8'h18;
      chk_outs("R5 fast1 and norm0 fields");
   endtask

   task automatic t_invert();
      wr(mk(8'hFF, 3'd5, 3'd2, 3'd6, 3'd7, 1'b1), 32'hFFFF_FFFF);
      src_in = 8'h00;
      chk_outs("R6 inverted externals low inputs");
      chk("R6 pattern low", {28'd0, norm_irq, fast_irq}, 32'hD);
      src_in = 8'hFF;
      chk_outs("R6 inverted externals high inputs");
      chk("R6 pattern high", {28'd0, norm_irq, fast_irq}, 32'h2);
      wr(32'h0, 32'h0010_0000);
      chk_outs("R6 inversion cleared by masked write");
   endtask

   task automatic t_timing();
      wr(mk(8'h00, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0), 32'hFFFF_FFFF);
      src_in = 8'h01;
      repeat (2) @(negedge clk);
      wr(32'h1, 32'h1);
      chk("R7 register updated", cfg_rdata, 32'h1);
      chk("R7 outputs not yet updated", {28'd0, norm_irq, fast_irq}, 32'h0);
      @(negedge clk);
      chk("R7 outputs one edge later", {28'd0, norm_irq, fast_irq}, 32'hF);
      src_in = 8'h00;
      chk("R7 source change not immediate", {28'd0, norm_irq, fast_irq}, 32'hF);
      @(negedge clk);
      chk("R7 source change after one edge", {28'd0, norm_irq, fast_irq}, 32'h0);
   endtask

   task automatic t_multi();
      wr(mk(8'hFF, 3'd0, 3'd0, 3'd7, 3'd3, 1'b0), 32'hFFFF_FFFF);
      for (int p = 0; p < 6; p++) begin
         src_in = 8'(8'h35 * (p + 1));
         chk_outs("R9 independent channels");
      end
      wr(mk(8'hAA, 3'd1, 3'd2, 3'd5, 3'd7, 1'b1), 32'hFFFF_FFFF);
      for (int p = 0; p < 6; p++) begin
         src_in = 8'(8'h4B * (p + 3));
         chk_outs("R9 mixed enables and inversion");
      end
   endtask

   initial begin
      t_reset();
      t_upper();
      t_mask();
      t_route();
      t_disabled();
      t_fields();
      t_invert();
      t_timing();
      t_multi();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule